// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block is the write-only configuration port of a frequency synthesizer. A controller writes it over three wires: a data line, a bit clock and a load-enable strobe. The serial lines are sampled in the core clock domain. While the strobe is low, every rising edge of the bit clock shifts one data bit into a 19-bit shift register, most significant bit first. When the strobe rises, the shifted word is committed to one of two holding registers. The bit received last selects which one.

The divide holding register supplies a 13-bit main count and a 5-bit swallow count to the feedback divider. The block also presents their combined ratio, 32 times the main count plus the swallow count. The reference holding register supplies a 13-bit reference count. Each commit raises a one-cycle reload pulse for the dividers.

An asynchronous active-high reset loads ratios that let the loop lock with no controller attached. A run-enable level is passed on as a registered standby indication. Serial writes keep working while the block is in standby.

Top module: `synth_cfg_port`

## Requirements
- R1: While `ser_le` is low, each rising edge of `ser_clk` shifts `ser_data` into the shift register, MSB first. The last bit shifted (bit 0) is the target bit. In a divide word (target 1), bits 18:6 are the main count and bits 5:1 are the swallow count. In a reference word (target 0), bits 13:1 are the reference count and bits 18:14 are ignored.
- R2: Rising edges of `ser_clk` while `ser_le` is high leave the shift register unchanged. This is observed by committing again without shifting any new bits.
- R3: A rising edge of `ser_le` copies the word into the holding register that the target bit selects. The other holding register keeps its value. Outside a commit, the holding registers do not change.
- R4: If more than 19 bits are shifted, only the 19 most recent bits are kept.
- R5: A committed main count below 32 is stored as 32. A committed reference count below 2 is stored as 2.
- R6: While `rst` is high, the outputs are: main count 324, swallow count 4, total ratio 10372, reference count 1280, `update_pulse` 0 and `standby` 1. Reset also clears the shift register, so a commit with no bits shifted afterwards writes a reference count of 0, which is stored as 2.
- R7: `total_div` equals 32 × `main_cnt` + `swallow_cnt`.
- R8: `update_pulse` is high for exactly one cycle after each commit. It is high in the same cycle in which the holding outputs first show the new values.
- R9: `standby` equals the inverse of `run_en` one cycle later. Shifting and commits work the same while `run_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Asynchronous reset, active high |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial bit clock, sampled by `clk` |
| ser_le | input | 1 | Load enable; low to shift, rising edge commits |
| run_en | input | 1 | 1 = run, 0 = standby |
| main_cnt | output | 13 | Held main count |
| swallow_cnt | output | 5 | Held swallow count |
| total_div | output | 18 | Feedback divide ratio |
| ref_cnt | output | 13 | Held reference count |
| update_pulse | output | 1 | One-cycle reload strobe after a commit |
| standby | output | 1 | Registered standby indication |

## Verification
The assertions assume that the serial lines are already synchronous to `clk` and that each level lasts at least one core clock period. Under that assumption every serial edge appears as exactly one sampled transition. The bench therefore changes `ser_clk`, `ser_data` and `ser_le` only on falling edges of `clk`, and holds every level for at least one full period. Reset is likewise held across at least one rising edge of `clk`. This lets the reset-value and hold-stability properties see settled register contents.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    // target bit value carried in the last bit of a serial word
    typedef enum logic {
        TGT_REF = 1'b0,
        TGT_DIV = 1'b1
    } cfg_tgt_e;
endpackage

// File: rtl/cfg_edge_det.sv
// Per-bit rising-edge detector; history resets high so no edge is seen at reset release.
module cfg_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);
    logic [N-1:0] hist_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or posedge rst) begin
            if (rst) hist_q[i] <= 1'b1;
            else     hist_q[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~hist_q[i];
    end
endmodule

// File: rtl/cfg_word_decode.sv
// Splits a shifted word into its target and fields, clamping counts to their minimums.
module cfg_word_decode
    import synth_cfg_pkg::*;
#(
    parameter int M_W   = 13,
    parameter int S_W   = 5,
    parameter int R_W   = 13,
    parameter int M_MIN = 32,
    parameter int R_MIN = 2,
    localparam int SR_W = M_W + S_W + 1
) (
    input  logic [SR_W-1:0] word,
    output cfg_tgt_e        tgt,
    output logic [M_W-1:0]  m_val,
    output logic [S_W-1:0]  s_val,
    output logic [R_W-1:0]  r_val
);
    logic [M_W-1:0] m_raw;
    logic [R_W-1:0] r_raw;

    always_comb begin
        tgt   = cfg_tgt_e'(word[0]);
        m_raw = word[SR_W-1 -: M_W];
        s_val = word[S_W:1];
        r_raw = word[R_W:1];
        m_val = (m_raw < M_W'(M_MIN)) ? M_W'(M_MIN) : m_raw;
        r_val = (r_raw < R_W'(R_MIN)) ? R_W'(R_MIN) : r_raw;
    end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int M_W   = 13,
    parameter int S_W   = 5,
    parameter int R_W   = 13,
    parameter int M_MIN = 32,
    parameter int R_MIN = 2,
    parameter int DEF_M = 324,
    parameter int DEF_S = 4,
    parameter int DEF_R = 1280,
    localparam int SR_W = M_W + S_W + 1,
    localparam int T_W  = M_W + S_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_data,
    input  logic           ser_clk,
    input  logic           ser_le,
    input  logic           run_en,
    output logic [M_W-1:0] main_cnt,
    output logic [S_W-1:0] swallow_cnt,
    output logic [T_W-1:0] total_div,
    output logic [R_W-1:0] ref_cnt,
    output logic           update_pulse,
    output logic           standby
);
    typedef struct packed {
        logic [SR_W-1:0] shreg;
        logic [M_W-1:0]  m;
        logic [S_W-1:0]  s;
        logic [R_W-1:0]  r;
        logic            pulse;
        logic            stby;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]     rise;
    logic           sclk_rise, le_rise;
    cfg_tgt_e       dec_tgt;
    logic [M_W-1:0] dec_m;
    logic [S_W-1:0] dec_s;
    logic [R_W-1:0] dec_r;

    cfg_edge_det #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  ({ser_le, ser_clk}),
        .rise (rise)
    );
    assign sclk_rise = rise[0];
    assign le_rise   = rise[1];

    cfg_word_decode #(
        .M_W(M_W), .S_W(S_W), .R_W(R_W), .M_MIN(M_MIN), .R_MIN(R_MIN)
    ) u_dec (
        .word  (st_q.shreg),
        .tgt   (dec_tgt),
        .m_val (dec_m),
        .s_val (dec_s),
        .r_val (dec_r)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.stby  = ~run_en;
        if (sclk_rise && !ser_le) begin
            st_d.shreg = {st_q.shreg[SR_W-2:0], ser_data};
        end
        if (le_rise) begin
            st_d.pulse = 1'b1;
            if (dec_tgt == TGT_DIV) begin
                st_d.m = dec_m;
                st_d.s = dec_s;
            end else begin
                st_d.r = dec_r;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.shreg <= '0;
            st_q.m     <= M_W'(DEF_M);
            st_q.s     <= S_W'(DEF_S);
            st_q.r     <= R_W'(DEF_R);
            st_q.pulse <= 1'b0;
            st_q.stby  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_cnt     = st_q.m;
    assign swallow_cnt  = st_q.s;
    assign total_div    = {st_q.m, st_q.s};
    assign ref_cnt      = st_q.r;
    assign update_pulse = st_q.pulse;
    assign standby      = st_q.stby;
endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk #(
    parameter int M_W   = 13,
    parameter int S_W   = 5,
    parameter int R_W   = 13,
    parameter int M_MIN = 32,
    parameter int R_MIN = 2,
    parameter int DEF_M = 324,
    parameter int DEF_S = 4,
    parameter int DEF_R = 1280
) (
    input logic           clk,
    input logic           rst,
    input logic           ser_le,
    input logic           run_en,
    input logic [M_W-1:0] main_cnt,
    input logic [S_W-1:0] swallow_cnt,
    input logic [R_W-1:0] ref_cnt,
    input logic           update_pulse,
    input logic           standby
);
    // R5
    min_main_chk: assert property (@(posedge clk) disable iff (rst)
        main_cnt >= M_W'(M_MIN));
    // R5
    min_ref_chk: assert property (@(posedge clk) disable iff (rst)
        ref_cnt >= R_W'(R_MIN));
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        update_pulse |=> !update_pulse);
    // R8
    pulse_after_le_chk: assert property (@(posedge clk) disable iff (rst)
        update_pulse |-> $past(ser_le));
    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !update_pulse |-> ($stable(main_cnt) && $stable(swallow_cnt) && $stable(ref_cnt)));
    // R9
    standby_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (standby == !$past(run_en)));
    // R6
    reset_value_chk: assert property (@(posedge clk)
        rst |-> (main_cnt == M_W'(DEF_M) && swallow_cnt == S_W'(DEF_S)
                 && ref_cnt == R_W'(DEF_R) && !update_pulse && standby));
endmodule

bind synth_cfg_port synth_cfg_port_chk #(
    .M_W(M_W), .S_W(S_W), .R_W(R_W), .M_MIN(M_MIN), .R_MIN(R_MIN),
    .DEF_M(DEF_M), .DEF_S(DEF_S), .DEF_R(DEF_R)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ser_le       (ser_le),
    .run_en       (run_en),
    .main_cnt     (main_cnt),
    .swallow_cnt  (swallow_cnt),
    .ref_cnt      (ref_cnt),
    .update_pulse (update_pulse),
    .standby      (standby)
);

// File: tb/synth_cfg_port_tb.sv
module synth_cfg_port_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        ser_data = 1'b0;
    logic        ser_clk  = 1'b0;
    logic        ser_le   = 1'b1;
    logic        run_en   = 1'b1;
    logic [12:0] main_cnt;
    logic [4:0]  swallow_cnt;
    logic [17:0] total_div;
    logic [12:0] ref_cnt;
    logic        update_pulse;
    logic        standby;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int em, es, er;

    always #10 clk = ~clk;

    synth_cfg_port u_dut (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_le(ser_le), .run_en(run_en), .main_cnt(main_cnt),
        .swallow_cnt(swallow_cnt), .total_div(total_div), .ref_cnt(ref_cnt),
        .update_pulse(update_pulse), .standby(standby)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(int'(main_cnt) == em, req, int'(main_cnt), em);
        chk(int'(swallow_cnt) == es, req, int'(swallow_cnt), es);
        chk(int'(ref_cnt) == er, req, int'(ref_cnt), er);
        chk(int'(total_div) == 32 * em + es, {req, "/R7"}, int'(total_div), 32 * em + es);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
            @(negedge clk); ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
    endtask

    // raise LE, then check pulse and registers one and two cycles later
    task automatic commit(input string req);
        @(negedge clk); ser_le = 1'b1;
        @(negedge clk);
        chk(update_pulse == 1'b1, {req, "/R8 pulse"}, int'(update_pulse), 1);
        chk_regs(req);
        @(negedge clk);
        chk(update_pulse == 1'b0, {req, "/R8 one cycle"}, int'(update_pulse), 0);
    endtask

    task automatic open_le();
        @(negedge clk); ser_le = 1'b0;
    endtask

    function automatic int clampv(input int v, input int lo);
        return (v < lo) ? lo : v;
    endfunction

    task automatic send_div(input int m, input int s, input string req);
        open_le();
        shift_bits({13'(m), 5'(s), 1'b1}, 19);
        em = clampv(m, 32); es = s;
        commit(req);
    endtask

    task automatic send_ref(input int r, input int junk, input string req);
        open_le();
        shift_bits({5'(junk), 13'(r), 1'b0}, 19);
        er = clampv(r, 2);
        commit(req);
    endtask

    initial begin
        int rvals[8] = '{0, 1, 2, 3, 1280, 4095, 8190, 8191};
        int mvals[8] = '{0, 1, 31, 32, 33, 324, 4096, 8191};
        rst = 1'b1;
        repeat (3) @(negedge clk);
        em = 324; es = 4; er = 1280;
        // R6 reset values
        chk_regs("R6 reset");
        chk(update_pulse == 1'b0, "R6 pulse", int'(update_pulse), 0);
        chk(standby == 1'b1, "R6 standby", int'(standby), 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(standby == 1'b0, "R9 run", int'(standby), 0);

        // R6 cleared shift register commits a zero reference word, clamped to 2
        open_le();
        er = 2;
        commit("R6 cleared shreg");

        // R1 R3 swallow sweep with varying main count
        for (int s = 0; s < 32; s++) send_div(40 + s * 251, s, "R1 div sweep");
        // R5 main clamp boundary
        foreach (mvals[i]) send_div(mvals[i], 31 - i, "R5 main");
        // R5 R3 reference values, upper junk bits ignored
        foreach (rvals[i]) send_ref(rvals[i], 5'h15 + i, "R5 ref");

        // R4 overlength: 6 leading junk bits then a valid divide word
        open_le();
        shift_bits({6'b101101, 13'd777, 5'd9, 1'b1}, 25);
        em = 777; es = 9;
        commit("R4 overlength");

        // R2 clock edges while LE high are ignored
        send_div(1234, 17, "R2 setup");
        for (int i = 0; i < 25; i++) begin
            @(negedge clk); ser_data = i[0]; ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
        open_le();
        commit("R2 relatch");

        // R9 standby keeps serial path working
        @(negedge clk); run_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(standby == 1'b1, "R9 standby", int'(standby), 1);
        send_ref(5000, 0, "R9 ref in standby");
        send_div(600, 3, "R9 div in standby");
        chk(standby == 1'b1, "R9 standby held", int'(standby), 1);
        @(negedge clk); run_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(standby == 1'b0, "R9 resume", int'(standby), 0);

        // R6 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        em = 324; es = 4; er = 1280;
        chk_regs("R6 mid reset");
        chk(int'(total_div) == 10372, "R6 total", int'(total_div), 10372);
        @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        chk_regs("R6 after release");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule